// File: doc/BRIEF.md
# Serial ADC Output Frame Emulator

This block is a synthesizable stand-in for the digital half of a successive-approximation converter's three-wire read port. A host controller under verification drives an active-low select and a serial clock. The testbench supplies a 14-bit unipolar result word and two sub-bits in parallel. The block returns that word as a fixed 24-bit serial frame: eight zero bits, then the result starting with its most significant bit, then the two sub-bits. It also reports whether the emulated converter is powered down.

Every pin is oversampled on a fast system clock, and timing is counted in serial clock edges only. The data pin is modelled as a value plus an output enable, and a pad outside the block builds the tri-state driver. A one-cycle strobe marks the moment the parallel word is captured. A bench can use it to confirm which word ended up in the frame.

Raising select at any point ends the frame. The counters and the captured word clear and the block powers down. The next select fall begins a new acquisition.

Top module: `sadc_frame_emu`

## Requirements
- R1: One clock after `cs_n_i` is sampled high, `pwr_down_o` is 1, `sdo_oe_o` is 0 and `sdo_o` is 0. While select stays high, serial clock activity changes none of the outputs.
- R2: One clock after `cs_n_i` is sampled low, `sdo_oe_o` is 1, `pwr_down_o` is 0 and `sdo_o` is 0.
- R3: `sdo_o` changes only in the clock that follows a sampled high-to-low transition of `sclk_i`. A rising transition leaves it unchanged.
- R4: Number the serial clock falls since select went low as k, with k = 0 before the first fall. Then `sdo_o` is 0 for k < 8, `code_i[21-k]` for 8 ≤ k ≤ 21, `sub_i[1]` for k = 22 and `sub_i[0]` for k = 23.
- R5: The word on `code_i`/`sub_i` at the sixth serial clock fall is captured, and `cap_stb_o` is 1 for exactly the clock in which k becomes 6. Changes to `code_i`/`sub_i` at any other time do not alter the frame.
- R6: For k ≥ 24, `sdo_o` is 0. The internal edge count saturates at 31, so trailing zeros continue for any number of further falls without the frame repeating.
- R7: Raising select mid-frame aborts at once. The next frame starts again at k = 0 and captures a fresh word at its own sixth fall.
- R8: The code is straight unipolar binary and goes out unchanged. Code 0 gives a frame that is all zeros, and code 16383 with sub-bits 11 gives sixteen ones after the leading zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| code_i | input | 14 | Parallel conversion result supplied by the bench |
| sub_i | input | 2 | Sub-bits appended after the result, bit 1 first |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Output enable for the data pad; 0 means high impedance |
| pwr_down_o | output | 1 | 1 while the emulated converter is shut down |
| cap_stb_o | output | 1 | One-clock pulse when the parallel word is captured |

## Verification
Two behaviours are hard to reach from the ports. The first is proof that the captured word is the one present at the sixth fall and no other. The bench presents the complement of the expected word until just before that fall and again right after it, so any capture at the wrong edge shows up as inverted bits in the frame. The second is saturation of the edge count. Each frame is driven well past 31 falls while select stays low, so a counter that wraps would put data bits back on the output where zeros are expected. Aborts are placed both before and after the capture edge, and each is followed by a full frame with a different word.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic {
    PWR_OFF = 1'b0,
    PWR_ON  = 1'b1
  } pwr_e;

  function automatic int frame_bits(input int lead, input int data_w, input int sub_w);
    return lead + data_w + sub_w;
  endfunction
endpackage

// File: rtl/sadc_edge_detect.sv
module sadc_edge_detect #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/sadc_edge_counter.sv
module sadc_edge_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            count_o <= '0;
    else if (clear_i)                      count_o <= '0;
    else if (step_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 5,
  parameter int ACQ_EDGE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] held_o,
  output logic              strobe_o
);
  localparam logic [CNT_W-1:0] PRE_ACQ = CNT_W'(ACQ_EDGE - 1);

  logic hit;
  assign hit = step_i && (count_i == PRE_ACQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o   <= '0;
      strobe_o <= 1'b0;
    end else if (clear_i) begin
      held_o   <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= hit;
      if (hit) held_o <= word_i;
    end
  end
endmodule

// File: rtl/sadc_frame_emu.sv
module sadc_frame_emu #(
  parameter int DATA_W   = 14,
  parameter int SUB_W    = 2,
  parameter int LEAD_W   = 8,
  parameter int ACQ_EDGE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic [SUB_W-1:0]  sub_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              pwr_down_o,
  output logic              cap_stb_o
);
  import sadc_pkg::*;

  localparam int WORD_W    = DATA_W + SUB_W;
  localparam int FRAME_LEN = frame_bits(LEAD_W, DATA_W, SUB_W);
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  pwr_e              pwr_q;
  logic              sclk_fall;
  logic              step;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] held_word;

  // Bit presented on the pad after k serial clock falls.
  function automatic logic bit_after_edge(input logic [CNT_W-1:0] k,
                                          input logic [WORD_W-1:0] w);
    int kk;
    logic b;
    kk = int'(k);
    b  = 1'b0;
    if (kk >= LEAD_W && kk < FRAME_LEN) b = w[FRAME_LEN - 1 - kk];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= PWR_OFF;
    else        pwr_q <= cs_n_i ? PWR_OFF : PWR_ON;
  end

  sadc_edge_detect #(.W(1)) u_sclk_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (sclk_i),
    .fall_o (sclk_fall)
  );

  assign step = sclk_fall && (pwr_q == PWR_ON) && !cs_n_i;

  sadc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cs_n_i),
    .step_i  (step),
    .count_o (bit_cnt)
  );

  sadc_capture #(
    .WORD_W   (WORD_W),
    .CNT_W    (CNT_W),
    .ACQ_EDGE (ACQ_EDGE)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (cs_n_i),
    .step_i   (step),
    .count_i  (bit_cnt),
    .word_i   ({code_i, sub_i}),
    .held_o   (held_word),
    .strobe_o (cap_stb_o)
  );

  assign sdo_oe_o   = (pwr_q == PWR_ON);
  assign pwr_down_o = (pwr_q == PWR_OFF);
  assign sdo_o      = sdo_oe_o && bit_after_edge(bit_cnt, held_word);
endmodule

// File: rtl/sadc_frame_chk.sv
module sadc_frame_chk #(
  parameter int DATA_W   = 14,
  parameter int SUB_W    = 2,
  parameter int LEAD_W   = 8,
  parameter int ACQ_EDGE = 6,
  parameter int CNT_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_i,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic             pwr_down_o,
  input logic             cap_stb_o,
  input logic             sclk_fall,
  input logic [CNT_W-1:0] bit_cnt
);
  localparam int FRAME_LEN = DATA_W + SUB_W + LEAD_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_cs_high_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> pwr_down_o && !sdo_oe_o && bit_cnt == '0);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_o |-> !sdo_o && !cap_stb_o);

  p_cs_low_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_i |=> sdo_oe_o && !pwr_down_o);

  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_n_i && sdo_oe_o) |=> $stable(sdo_o));

  p_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && int'(bit_cnt) < LEAD_W) |-> !sdo_o);

  p_strobe_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb_o |-> (int'(bit_cnt) == ACQ_EDGE) && sdo_oe_o);

  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bit_cnt) >= FRAME_LEN) |-> !sdo_o);

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CNT_MAX) |=> (bit_cnt == CNT_MAX || bit_cnt == '0));

  p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && sdo_oe_o) |=> !cap_stb_o && bit_cnt == '0 && !sdo_oe_o);
endmodule

bind sadc_frame_emu sadc_frame_chk #(
  .DATA_W   (DATA_W),
  .SUB_W    (SUB_W),
  .LEAD_W   (LEAD_W),
  .ACQ_EDGE (ACQ_EDGE),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_i     (cs_n_i),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .pwr_down_o (pwr_down_o),
  .cap_stb_o  (cap_stb_o),
  .sclk_fall  (sclk_fall),
  .bit_cnt    (bit_cnt)
);

// File: tb/sim_sadc_frame_emu.sv
module sim_sadc_frame_emu;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // Each entry: {14-bit code, 2 sub-bits} then the expected 24-bit stream.
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h0000, 24'h000000},
    {16'hFFFF, 24'h00FFFF},
    {16'hAAA9, 24'h00AAA9},
    {16'h5556, 24'h005556},
    {16'h0004, 24'h000004},
    {16'h8001, 24'h008001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [13:0] code = '0;
  logic [1:0]  sub = '0;
  logic        sdo, sdo_oe, pwr_down, cap_stb;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_frame_emu u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n),
    .sclk_i     (sclk),
    .code_i     (code),
    .sub_i      (sub),
    .sdo_o      (sdo),
    .sdo_oe_o   (sdo_oe),
    .pwr_down_o (pwr_down),
    .cap_stb_o  (cap_stb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_word(input logic [15:0] w);
    code = w[15:2];
    sub  = w[1:0];
  endtask

  task automatic fall();
    sclk = 1'b0;
    tick();
  endtask

  task automatic rise();
    sclk = 1'b1;
    tick();
  endtask

  task automatic run_frame(input logic [15:0] w, input logic [23:0] stream);
    logic prev;
    put_word(~w);
    cs_n = 1'b0;
    tick();
    check("R2 oe after select low", 32'(sdo_oe), 32'd1);
    check("R2 power flag after select low", 32'(pwr_down), 32'd0);
    check("R4 bit k=0", 32'(sdo), 32'(stream[23]));
    for (int k = 1; k <= 23; k++) begin
      if (k == 6) put_word(w);
      prev = sdo;
      rise();
      check("R3 no change on rising edge", 32'(sdo), 32'(prev));
      fall();
      check($sformatf("R4 R8 bit k=%0d", k), 32'(sdo), 32'(stream[23-k]));
      if (k == 6) begin
        check("R5 strobe at sixth fall", 32'(cap_stb), 32'd1);
        put_word(~w);
      end
      if (k == 7) check("R5 strobe single cycle", 32'(cap_stb), 32'd0);
    end
    for (int k = 24; k <= 44; k++) begin
      rise();
      fall();
      check($sformatf("R6 trailing zero k=%0d", k), 32'(sdo), 32'd0);
    end
    cs_n = 1'b1;
    tick();
    check("R1 power down after select high", 32'(pwr_down), 32'd1);
    check("R1 high impedance after select high", 32'(sdo_oe), 32'd0);
    tick();
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset power flag", 32'(pwr_down), 32'd1);
    check("R1 reset oe", 32'(sdo_oe), 32'd0);
    check("R1 reset sdo", 32'(sdo), 32'd0);
    check("R5 reset strobe", 32'(cap_stb), 32'd0);
    rst_n = 1'b1;
    tick();

    // Main table: R4 ordering and R8 coding, with R5 capture and R6 trailing zeros.
    for (int v = 0; v < NVEC; v++) run_frame(VEC[v][39:24], VEC[v][23:0]);

    // R1: serial clock activity while deselected is ignored.
    put_word(16'hFFFF);
    for (int i = 0; i < 10; i++) begin
      rise();
      fall();
      check("R1 ignored clock oe", 32'(sdo_oe), 32'd0);
      check("R1 ignored clock sdo", 32'(sdo), 32'd0);
    end
    run_frame(16'h8001, 24'h008001);

    // R7: abort after capture, then a fresh frame.
    put_word(16'hFFFF);
    cs_n = 1'b0;
    tick();
    for (int k = 1; k <= 12; k++) begin
      rise();
      fall();
    end
    check("R7 mid-frame data present", 32'(sdo), 32'd1);
    cs_n = 1'b1;
    tick();
    check("R7 abort powers down", 32'(pwr_down), 32'd1);
    check("R7 abort releases pad", 32'(sdo_oe), 32'd0);
    tick();
    run_frame(16'h5556, 24'h005556);

    // R7: abort before capture, then a fresh frame.
    cs_n = 1'b0;
    tick();
    for (int k = 1; k <= 3; k++) begin
      rise();
      fall();
    end
    cs_n = 1'b1;
    tick();
    check("R7 early abort powers down", 32'(pwr_down), 32'd1);
    tick();
    run_frame(16'hAAA9, 24'h00AAA9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule